// File: doc/BRIEF.md
# Protected-Mode Interrupt-Return Sequencer

This block carries out the return from an interrupt or exception handler when the processor runs with segment protection enabled. A pulse on `start` hands it the current privilege level, the big/small attribute and base address of the current stack segment, the current stack pointer, the current flags and the operand size of the return. The sequencer reads the return frame word by word through a single memory read port. It fetches the high word of the target code descriptor, and of the target stack descriptor when the privilege level changes, through a descriptor read port. It applies the protection rules to those words.

The operation ends with a one-cycle pulse of one of two kinds. A commit pulse presents the new instruction pointer, stack pointer, flags and segment selectors for the surrounding core to load. A fault pulse presents a fault class and the selector at fault. On a fault nothing is committed. When a 32-bit frame carries the virtual-8086 flag, a longer frame holding the stack pointer and all data segment selectors is popped with no descriptor checks. The commit pulse then tells the core to load every segment in real-address style: base = selector × 16, limit 0xFFFF, attributes zero.

Top module: `iret_sequencer`

## Requirements
- R1: After reset `busy`, `wb_valid` and `flt_valid` are low. `busy` is high from the cycle after an accepted `start` through the cycle of the `wb_valid` or `flt_valid` pulse, and low in the cycle after it. A `start` (and any input change) while busy has no effect on the running operation.
- R2: Frame word k is read at `cur_ss_base + sp + k*w`, with w = 4 for a 32-bit return and w = 2 for a 16-bit one. sp is `cur_esp` when `cur_ss_big` is 1 and its low 16 bits otherwise. In a 16-bit return only the low 16 bits of each read word are used.
- R3: Frame words 0, 1 and 2 are the new instruction pointer, the new code selector (low 16 bits only) and the new flags.
- R4: A general-protection fault (`flt_code` = 1, `flt_sel` = code selector & 0xFFFC) results from any of these: a null code selector (bits 15:2 zero); `desc_ok` low; a descriptor that is not code (bit 12 = segment, bit 11 = code, both required); selector RPL (bits 1:0) below `cur_cpl`; or a DPL (bits 14:13) rule violation. For conforming code (bit 10 set) the rule is DPL > RPL. Otherwise it is DPL ≠ RPL.
- R5: A code descriptor that passes R4 but has its present bit (bit 15) clear gives a not-present fault (`flt_code` = 2) on the code selector.
- R6: When RPL equals the current privilege level, the committed stack pointer value is sp + 12 for a 32-bit return and sp + 6 for a 16-bit one. No stack selector is loaded (`wb_ss_load` = 0).
- R7: When RPL differs, frame words 3 and 4 give the new stack pointer and stack selector. A stack selector whose RPL differs from the code RPL is a general-protection fault, checked before the descriptor read. So is `desc_ok` low, or a descriptor that is not a writable data segment (bit 12 set, bit 11 clear, bit 9 set) with DPL equal to RPL. A present bit clear is a not-present fault. The selector at fault is stack selector & 0xFFFC.
- R8: If the stack segment in force after the return has its big bit set (the current one for R6, descriptor bit 22 for R7), `wb_esp` is the whole new value. Otherwise `wb_esp` keeps the upper 16 bits of `cur_esp` and takes the low 16 bits of the new value.
- R9: Flags bits 0, 2, 4, 6, 7, 10 and 11 always come from the popped word. The other bits come from it only under the update mask; the rest keep `cur_eflags`. At privilege 0 the mask is 0x00257300, otherwise 0x00240100. For a 16-bit return it is cut to its low 16 bits.
- R10: In a 32-bit return whose popped flags have bit 17 set, words 3..8 give stack pointer, SS, ES, DS, FS and GS (selectors low 16 bits). No descriptor is read. The commit has `wb_vm86` = 1, `wb_ss_load` = 1, the full stack pointer, and the update mask 0x003F7300.
- R11: After any fault no `wb_valid` pulse is given for that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a return (taken only when idle) |
| op32 | input | 1 | 1 = 32-bit frame, 0 = 16-bit frame |
| cur_cpl | input | 2 | Current privilege level |
| cur_ss_big | input | 1 | Big bit of the current stack segment |
| cur_ss_base | input | 32 | Base address of the current stack segment |
| cur_esp | input | 32 | Current stack pointer |
| cur_eflags | input | 32 | Current flags |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Frame read request |
| mem_addr | output | 32 | Frame read address |
| mem_ack | input | 1 | Frame read data valid |
| mem_rdata | input | 32 | Frame read data |
| desc_req | output | 1 | Descriptor read request |
| desc_sel | output | 16 | Selector whose descriptor is wanted |
| desc_ack | input | 1 | Descriptor response valid |
| desc_ok | input | 1 | Selector lies within its table limit |
| desc_hi | input | 32 | High word of the descriptor |
| wb_valid | output | 1 | Commit pulse |
| wb_eip | output | 32 | New instruction pointer |
| wb_esp | output | 32 | New stack pointer |
| wb_eflags | output | 32 | New flags |
| wb_cs | output | 16 | New code selector |
| wb_ss | output | 16 | New stack selector |
| wb_ss_load | output | 1 | Stack selector is to be loaded |
| wb_vm86 | output | 1 | Load all segments in real-address style |
| wb_es | output | 16 | New ES selector (vm86 only) |
| wb_ds | output | 16 | New DS selector (vm86 only) |
| wb_fs | output | 16 | New FS selector (vm86 only) |
| wb_gs | output | 16 | New GS selector (vm86 only) |
| flt_valid | output | 1 | Fault pulse |
| flt_code | output | 2 | 1 = general protection, 2 = not present |
| flt_sel | output | 16 | Selector at fault, RPL bits cleared |

## Verification
The hardest state to reach is a fault raised on the stack descriptor at the very end of an outer-privilege return. By then the code descriptor has passed every rule and two extra frame words have been read. The stimulus builds a legal frame with a higher code RPL and a valid code descriptor, then corrupts only the stack side: wrong selector RPL, read-only data, or present bit clear. The 16-bit stack-pointer wrap (sp = 0xFFFA) and the virtual-8086 frame are reached the same way, by crafted frame contents. The bench memory model returns a poison word for any address off the expected frame, so a wrong address also shows up as a wrong result.

// File: rtl/iret_sequencer.sv
module iret_sequencer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op32,
  input  logic [1:0]  cur_cpl,
  input  logic        cur_ss_big,
  input  logic [31:0] cur_ss_base,
  input  logic [31:0] cur_esp,
  input  logic [31:0] cur_eflags,
  output logic        busy,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        desc_req,
  output logic [15:0] desc_sel,
  input  logic        desc_ack,
  input  logic        desc_ok,
  input  logic [31:0] desc_hi,
  output logic        wb_valid,
  output logic [31:0] wb_eip,
  output logic [31:0] wb_esp,
  output logic [31:0] wb_eflags,
  output logic [15:0] wb_cs,
  output logic [15:0] wb_ss,
  output logic        wb_ss_load,
  output logic        wb_vm86,
  output logic [15:0] wb_es,
  output logic [15:0] wb_ds,
  output logic [15:0] wb_fs,
  output logic [15:0] wb_gs,
  output logic        flt_valid,
  output logic [1:0]  flt_code,
  output logic [15:0] flt_sel
);

  localparam int          NWORDS    = 9;
  localparam logic [31:0] FIXED_M   = 32'h0000_0CD5;
  localparam logic [31:0] KERN_M    = 32'h0025_7300;
  localparam logic [31:0] USER_M    = 32'h0024_0100;
  localparam logic [31:0] V86_M     = 32'h001A_0000;
  localparam logic [1:0]  FC_GP     = 2'd1;
  localparam logic [1:0]  FC_NP     = 2'd2;
  localparam int          VM_BIT    = 17;

  typedef enum logic [2:0] {S_IDLE, S_POP, S_CSD, S_SSD, S_DONE, S_FLT} st_t;

  st_t         st;
  logic [3:0]  slot;
  logic        op32_q, big_q, vm_q, outer_q, newbig_q;
  logic [1:0]  cpl_q;
  logic [31:0] base_q, esp_q, fl_q, sp_q;
  logic [31:0] fr [NWORDS];
  logic [1:0]  fcode_q;
  logic [15:0] fsel_q;

  logic        keep16;
  logic [31:0] rd_val;
  logic [15:0] cs_sel, ss_sel;
  logic [1:0]  rpl, dpl;
  logic        cs_gp, ss_gp, d_np;
  logic [31:0] upd_m, full_m, raw_esp;
  logic        eff_big;
  logic        unused_desc;

  assign keep16  = !op32_q || slot == 4'd1 || slot >= 4'd4;
  assign rd_val  = keep16 ? {16'd0, mem_rdata[15:0]} : mem_rdata;
  assign cs_sel  = fr[1][15:0];
  assign ss_sel  = fr[4][15:0];
  assign rpl     = cs_sel[1:0];
  assign dpl     = desc_hi[14:13];
  assign d_np    = !desc_hi[15];

  assign cs_gp = !desc_ok || !desc_hi[12] || !desc_hi[11] || (rpl < cpl_q) ||
                 (desc_hi[10] ? (dpl > rpl) : (dpl != rpl));
  assign ss_gp = !desc_ok || !desc_hi[12] || desc_hi[11] || !desc_hi[9] ||
                 (dpl != rpl);

  assign unused_desc = ^{desc_hi[31:23], desc_hi[21:16], desc_hi[8:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      slot     <= '0;
      op32_q   <= 1'b0;
      big_q    <= 1'b0;
      vm_q     <= 1'b0;
      outer_q  <= 1'b0;
      newbig_q <= 1'b0;
      cpl_q    <= '0;
      base_q   <= '0;
      esp_q    <= '0;
      fl_q     <= '0;
      sp_q     <= '0;
      fcode_q  <= '0;
      fsel_q   <= '0;
      for (int i = 0; i < NWORDS; i++) fr[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op32_q  <= op32;
          big_q   <= cur_ss_big;
          cpl_q   <= cur_cpl;
          base_q  <= cur_ss_base;
          esp_q   <= cur_esp;
          fl_q    <= cur_eflags;
          sp_q    <= cur_ss_big ? cur_esp : {16'd0, cur_esp[15:0]};
          slot    <= '0;
          vm_q    <= 1'b0;
          outer_q <= 1'b0;
          st      <= S_POP;
        end
        S_POP: if (mem_ack) begin
          fr[slot] <= rd_val;
          if (slot == 4'd2) begin
            if (op32_q && mem_rdata[VM_BIT]) begin
              vm_q <= 1'b1;
              slot <= 4'd3;
            end else if (cs_sel[15:2] == 14'd0) begin
              fcode_q <= FC_GP;
              fsel_q  <= 16'd0;
              st      <= S_FLT;
            end else begin
              st <= S_CSD;
            end
          end else if (slot == 4'd4 && !vm_q) begin
            if (rd_val[1:0] != rpl) begin
              fcode_q <= FC_GP;
              fsel_q  <= {rd_val[15:2], 2'b00};
              st      <= S_FLT;
            end else begin
              st <= S_SSD;
            end
          end else if (slot == 4'(NWORDS - 1)) begin
            st <= S_DONE;
          end else begin
            slot <= slot + 4'd1;
          end
        end
        S_CSD: if (desc_ack) begin
          if (cs_gp || d_np) begin
            fcode_q <= cs_gp ? FC_GP : FC_NP;
            fsel_q  <= {cs_sel[15:2], 2'b00};
            st      <= S_FLT;
          end else if (rpl == cpl_q) begin
            st <= S_DONE;
          end else begin
            outer_q <= 1'b1;
            slot    <= 4'd3;
            st      <= S_POP;
          end
        end
        S_SSD: if (desc_ack) begin
          if (ss_gp || d_np) begin
            fcode_q <= ss_gp ? FC_GP : FC_NP;
            fsel_q  <= {ss_sel[15:2], 2'b00};
            st      <= S_FLT;
          end else begin
            newbig_q <= desc_hi[22];
            st       <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = st != S_IDLE;
  assign mem_req   = st == S_POP;
  assign mem_addr  = base_q + sp_q + ({28'd0, slot} << (op32_q ? 2 : 1));
  assign desc_req  = st == S_CSD || st == S_SSD;
  assign desc_sel  = st == S_SSD ? ss_sel : cs_sel;

  assign upd_m   = vm_q ? (KERN_M | V86_M)
                 : ((cpl_q == 2'd0 ? KERN_M : USER_M) & (op32_q ? 32'hFFFF_FFFF : 32'h0000_FFFF));
  assign full_m  = upd_m | FIXED_M;
  assign raw_esp = (vm_q || outer_q) ? fr[3] : sp_q + (op32_q ? 32'd12 : 32'd6);
  assign eff_big = outer_q ? newbig_q : big_q;

  assign wb_valid   = st == S_DONE;
  assign wb_eip     = fr[0];
  assign wb_cs      = cs_sel;
  assign wb_eflags  = (fl_q & ~full_m) | (fr[2] & full_m);
  assign wb_esp     = (vm_q || eff_big) ? raw_esp : {esp_q[31:16], raw_esp[15:0]};
  assign wb_ss_load = vm_q || outer_q;
  assign wb_ss      = wb_ss_load ? ss_sel : 16'd0;
  assign wb_vm86    = vm_q;
  assign wb_es      = vm_q ? fr[5][15:0] : 16'd0;
  assign wb_ds      = vm_q ? fr[6][15:0] : 16'd0;
  assign wb_fs      = vm_q ? fr[7][15:0] : 16'd0;
  assign wb_gs      = vm_q ? fr[8][15:0] : 16'd0;

  assign flt_valid = st == S_FLT;
  assign flt_code  = fcode_q;
  assign flt_sel   = fsel_q;

  a_r1_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || flt_valid) |=> !busy);

  a_r1_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wb_valid && !flt_valid) |=> busy);

  a_r4_rpl_not_below_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_vm86) |-> (wb_cs[1:0] >= cpl_q));

  a_r7_ss_rpl_match: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ss_load && !wb_vm86) |-> (wb_ss[1:0] == wb_cs[1:0]));

  a_r11_fault_class: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (flt_code == FC_GP || flt_code == FC_NP));

  a_r10_no_desc_on_v86: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vm_q) |-> !desc_req);

endmodule

// File: tb/iret_sequencer_tb.sv
module iret_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 0, op32 = 0, cur_ss_big = 0;
  logic [1:0]  cur_cpl = 0;
  logic [31:0] cur_ss_base = 0, cur_esp = 0, cur_eflags = 0;
  logic        busy, mem_req, mem_ack, desc_req, desc_ack, desc_ok;
  logic [31:0] mem_addr, mem_rdata, desc_hi;
  logic [15:0] desc_sel;
  logic        wb_valid, wb_ss_load, wb_vm86, flt_valid;
  logic [31:0] wb_eip, wb_esp, wb_eflags;
  logic [15:0] wb_cs, wb_ss, wb_es, wb_ds, wb_fs, wb_gs, flt_sel;
  logic [1:0]  flt_code;

  iret_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op32(op32), .cur_cpl(cur_cpl),
    .cur_ss_big(cur_ss_big), .cur_ss_base(cur_ss_base), .cur_esp(cur_esp),
    .cur_eflags(cur_eflags), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .desc_req(desc_req), .desc_sel(desc_sel),
    .desc_ack(desc_ack), .desc_ok(desc_ok), .desc_hi(desc_hi), .wb_valid(wb_valid),
    .wb_eip(wb_eip), .wb_esp(wb_esp), .wb_eflags(wb_eflags), .wb_cs(wb_cs),
    .wb_ss(wb_ss), .wb_ss_load(wb_ss_load), .wb_vm86(wb_vm86), .wb_es(wb_es),
    .wb_ds(wb_ds), .wb_fs(wb_fs), .wb_gs(wb_gs), .flt_valid(flt_valid),
    .flt_code(flt_code), .flt_sel(flt_sel)
  );

  logic [31:0] fw [9];
  logic [31:0] tb_frame = 0;
  int          tb_w = 4;
  logic [15:0] tb_cs = 0, tb_ss = 0;
  logic [31:0] cs_dh = 0, ss_dh = 0;
  logic        tb_dok = 1;
  logic        poke = 0;

  always_comb begin
    mem_ack   = mem_req;
    mem_rdata = 32'hDEAD_BEEF;
    for (int i = 0; i < 9; i++)
      if (mem_addr == tb_frame + 32'(i * tb_w)) mem_rdata = fw[i];
  end

  always_comb begin
    desc_ack = desc_req;
    desc_ok  = tb_dok;
    if (desc_sel == tb_cs)      desc_hi = cs_dh;
    else if (desc_sel == tb_ss) desc_hi = ss_dh;
    else                        desc_hi = 32'd0;
  end

  int checks = 0, failures = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_fl(input logic [31:0] cur, input logic [31:0] pop,
                                         input logic [1:0] cpl, input logic o32, input logic v86);
    logic [31:0] m;
    if (v86)             m = 32'h003F_7300;
    else if (cpl == 2'd0) m = 32'h0025_7300;
    else                 m = 32'h0024_0100;
    if (!o32) m = m & 32'h0000_FFFF;
    m = m | 32'h0000_0CD5;
    return (cur & ~m) | (pop & m);
  endfunction

  logic        c_wb, c_flt, c_busy_early, c_busy_after, c_ssl, c_v86;
  logic [31:0] c_eip, c_esp, c_fl;
  logic [15:0] c_cs, c_ss, c_es, c_ds, c_fs, c_gs, c_sel;
  logic [1:0]  c_code;

  task automatic setup(input logic o32, input logic [1:0] cpl, input logic big,
                       input logic [31:0] base, input logic [31:0] esp, input logic [31:0] fl);
    op32 = o32; cur_cpl = cpl; cur_ss_big = big; cur_ss_base = base;
    cur_esp = esp; cur_eflags = fl;
    tb_w = o32 ? 4 : 2;
    tb_frame = base + (big ? esp : {16'd0, esp[15:0]});
    tb_dok = 1;
    for (int i = 0; i < 9; i++) fw[i] = 32'hDEAD_BEEF;
  endtask

  task automatic go();
    int n;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; c_busy_early = busy;
    if (poke) begin
      start = 1; cur_cpl = 2'd3; cur_esp = 32'h0; op32 = ~op32;
      @(negedge clk); start = 0;
    end
    n = 0;
    while (!(wb_valid || flt_valid) && n < 100) begin @(negedge clk); n++; end
    if (n >= 100) chk("R1", "watchdog", 32'd1, 32'd0);
    c_wb = wb_valid; c_flt = flt_valid; c_eip = wb_eip; c_esp = wb_esp; c_fl = wb_eflags;
    c_cs = wb_cs; c_ss = wb_ss; c_ssl = wb_ss_load; c_v86 = wb_vm86;
    c_es = wb_es; c_ds = wb_ds; c_fs = wb_fs; c_gs = wb_gs;
    c_code = flt_code; c_sel = flt_sel;
    @(negedge clk); c_busy_after = busy;
  endtask

  task automatic t_reset();
    chk("R1", "busy after reset", {31'd0, busy}, 32'd0);
    chk("R1", "wb_valid after reset", {31'd0, wb_valid}, 32'd0);
    chk("R1", "flt_valid after reset", {31'd0, flt_valid}, 32'd0);
  endtask

  task automatic prep_same32();
    setup(1, 2'd0, 1, 32'h0000_1000, 32'h0000_2000, 32'h0000_0002);
    fw[0] = 32'h1234_5678; fw[1] = 32'hBEEF_0008; fw[2] = 32'h0025_7FFF;
    tb_cs = 16'h0008; cs_dh = 32'h0000_9A00; tb_ss = 16'hFFFF; ss_dh = 0;
  endtask

  task automatic t_same32();
    prep_same32();
    go();
    chk("R1", "busy during op", {31'd0, c_busy_early}, 32'd1);
    chk("R1", "idle after commit", {31'd0, c_busy_after}, 32'd0);
    chk("R3", "commit 32-bit same", {31'd0, c_wb}, 32'd1);
    chk("R3", "eip", c_eip, 32'h1234_5678);
    chk("R3", "cs low half", {16'd0, c_cs}, 32'h0000_0008);
    chk("R6", "esp sp+12", c_esp, 32'h0000_200C);
    chk("R6", "no ss load", {31'd0, c_ssl}, 32'd0);
    chk("R9", "eflags kernel 32", c_fl, exp_fl(32'h2, 32'h0025_7FFF, 2'd0, 1, 0));
  endtask

  task automatic t_same16();
    setup(0, 2'd3, 0, 32'h0001_0000, 32'hABCD_FFFA, 32'h0000_3202);
    fw[0] = 32'h9999_4321; fw[1] = 32'h7777_001B; fw[2] = 32'hFFFF_FFFF;
    tb_cs = 16'h001B; cs_dh = 32'h0000_FA00; tb_ss = 16'hFFFF;
    go();
    chk("R2", "commit 16-bit", {31'd0, c_wb}, 32'd1);
    chk("R2", "eip masked to 16", c_eip, 32'h0000_4321);
    chk("R8", "esp low replaced with wrap", c_esp, 32'hABCD_0000);
    chk("R9", "eflags user 16", c_fl, exp_fl(32'h3202, 32'h0000_FFFF, 2'd3, 0, 0));
  endtask

  task automatic t_outer32();
    setup(1, 2'd0, 1, 32'h0000_0000, 32'h4444_1000, 32'h0000_0202);
    fw[0] = 32'h0040_0000; fw[1] = 32'h0000_0023; fw[2] = 32'h0000_08C3;
    fw[3] = 32'h1357_9BDF; fw[4] = 32'hFFFF_002B;
    tb_cs = 16'h0023; cs_dh = 32'h0000_FA00; tb_ss = 16'h002B; ss_dh = 32'h0000_F200;
    go();
    chk("R7", "commit outer 32", {31'd0, c_wb}, 32'd1);
    chk("R7", "ss loaded", {31'd0, c_ssl}, 32'd1);
    chk("R7", "ss selector", {16'd0, c_ss}, 32'h0000_002B);
    chk("R8", "esp small ss", c_esp, 32'h4444_9BDF);
    chk("R9", "eflags kernel outer", c_fl, exp_fl(32'h202, 32'h8C3, 2'd0, 1, 0));
  endtask

  task automatic t_outer16();
    setup(0, 2'd1, 0, 32'h0002_0000, 32'h5555_0100, 32'h0000_0000);
    fw[0] = 32'h0000_0010; fw[1] = 32'h0000_0012; fw[2] = 32'h0000_0400;
    fw[3] = 32'hAAAA_7777; fw[4] = 32'h0000_001A;
    tb_cs = 16'h0012; cs_dh = 32'h0000_BE00; tb_ss = 16'h001A; ss_dh = 32'h0040_D200;
    go();
    chk("R4", "conforming dpl<rpl accepted", {31'd0, c_wb}, 32'd1);
    chk("R8", "esp full with big ss", c_esp, 32'h0000_7777);
    chk("R9", "direction flag bit 10", c_fl, 32'h0000_0400);
  endtask

  task automatic t_v86();
    setup(1, 2'd0, 1, 32'h0000_8000, 32'h0000_0040, 32'h0000_0002);
    fw[0] = 32'h0000_0100; fw[1] = 32'hAAAA_1234; fw[2] = 32'h0002_0202;
    fw[3] = 32'h0000_FFF0; fw[4] = 32'hAAAA_2000; fw[5] = 32'hAAAA_3000;
    fw[6] = 32'hAAAA_4000; fw[7] = 32'hAAAA_5000; fw[8] = 32'hAAAA_6000;
    tb_dok = 0; tb_cs = 16'hFFFF; tb_ss = 16'hFFFF;
    go();
    chk("R10", "commit v86", {31'd0, c_wb}, 32'd1);
    chk("R10", "vm86 flag", {31'd0, c_v86}, 32'd1);
    chk("R10", "cs", {16'd0, c_cs}, 32'h0000_1234);
    chk("R10", "ss", {16'd0, c_ss}, 32'h0000_2000);
    chk("R10", "es", {16'd0, c_es}, 32'h0000_3000);
    chk("R10", "ds", {16'd0, c_ds}, 32'h0000_4000);
    chk("R10", "fs", {16'd0, c_fs}, 32'h0000_5000);
    chk("R10", "gs", {16'd0, c_gs}, 32'h0000_6000);
    chk("R10", "esp", c_esp, 32'h0000_FFF0);
    chk("R10", "eflags", c_fl, exp_fl(32'h2, 32'h0002_0202, 2'd0, 1, 1));
  endtask

  task automatic t_fault(input string req, input string what, input logic [1:0] code, input logic [15:0] sel);
    go();
    chk(req, {what, " fault"}, {31'd0, c_flt}, 32'd1);
    chk(req, {what, " code"}, {30'd0, c_code}, {30'd0, code});
    chk(req, {what, " sel"}, {16'd0, c_sel}, {16'd0, sel});
    chk("R11", {what, " no commit"}, {31'd0, c_wb}, 32'd0);
    chk("R1", {what, " idle after fault"}, {31'd0, c_busy_after}, 32'd0);
  endtask

  task automatic t_faults();
    prep_same32(); fw[1] = 32'h0000_0003;
    t_fault("R4", "null cs", 2'd1, 16'h0000);
    prep_same32(); tb_dok = 0;
    t_fault("R4", "cs out of table", 2'd1, 16'h0008);
    prep_same32(); cs_dh = 32'h0000_9200;
    t_fault("R4", "cs not code", 2'd1, 16'h0008);
    prep_same32(); cur_cpl = 2'd2; fw[1] = 32'h0000_0009; tb_cs = 16'h0009; cs_dh = 32'h0000_BA00;
    t_fault("R4", "rpl below cpl", 2'd1, 16'h0008);
    prep_same32(); fw[1] = 32'h0000_0011; tb_cs = 16'h0011; cs_dh = 32'h0000_DE00;
    t_fault("R4", "conforming dpl>rpl", 2'd1, 16'h0010);
    prep_same32(); fw[1] = 32'h0000_0011; tb_cs = 16'h0011; cs_dh = 32'h0000_9A00;
    t_fault("R4", "nonconforming dpl!=rpl", 2'd1, 16'h0010);
    prep_same32(); cs_dh = 32'h0000_1A00;
    t_fault("R5", "cs not present", 2'd2, 16'h0008);
    t_outer32_prep(); fw[4] = 32'h0000_0029; tb_ss = 16'h0029;
    t_fault("R7", "ss rpl mismatch", 2'd1, 16'h0028);
    t_outer32_prep(); ss_dh = 32'h0000_F000;
    t_fault("R7", "ss read-only", 2'd1, 16'h0028);
    t_outer32_prep(); ss_dh = 32'h0000_7200;
    t_fault("R7", "ss not present", 2'd2, 16'h0028);
  endtask

  task automatic t_outer32_prep();
    setup(1, 2'd0, 1, 32'h0000_0000, 32'h4444_1000, 32'h0000_0202);
    fw[0] = 32'h0040_0000; fw[1] = 32'h0000_0023; fw[2] = 32'h0000_08C3;
    fw[3] = 32'h1357_9BDF; fw[4] = 32'h0000_002B;
    tb_cs = 16'h0023; cs_dh = 32'h0000_FA00; tb_ss = 16'h002B; ss_dh = 32'h0000_F200;
  endtask

  task automatic t_start_ignored();
    prep_same32();
    poke = 1;
    go();
    poke = 0;
    chk("R1", "restart ignored commit", {31'd0, c_wb}, 32'd1);
    chk("R1", "restart ignored esp", c_esp, 32'h0000_200C);
    chk("R1", "restart ignored eflags", c_fl, exp_fl(32'h2, 32'h0025_7FFF, 2'd0, 1, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_same32();
    t_same16();
    t_outer32();
    t_outer16();
    t_v86();
    t_faults();
    t_start_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R1 global watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule